// File: doc/BRIEF.md
# Display PLL Divider Search Engine

This block picks integer settings for a display clock synthesiser so that the synthesised frequency lands as close as possible to a requested pixel clock. The synthesiser divides a reference by an input ratio M+1 and multiplies it by a feedback ratio N+1 to reach an intermediate (VCO) frequency. A post divider of FD+1 then brings that down to the output. Software or a mode-set sequencer places the reference and target frequencies, both in hertz, on the inputs and pulses `start`. The engine then walks every allowed candidate in a fixed order and reports the best one.

The walk is fixed. M rises from 0 to 3, N falls from 119 to 39, and FD rises from 1 to 31. This order favours low jitter: a small input divider and a large feedback multiplier come first. Because only a strictly smaller error replaces the stored best, the earliest candidate in the walk wins any tie. VCO frequencies outside the allowed window are pruned before any post division is tried, and outputs at or above the output ceiling are discarded. Each division runs on a shared restoring divider that retires several quotient bits per cycle, so a candidate costs a handful of cycles. The search ends early as soon as an exact match appears.

Top module: `pll_div_search`

## Requirements
- R1: After reset `busy`, `done` and `found` are 0, and `m_sel`, `n_sel`, `fd_sel`, `out_hz` and `err_hz` are all 0.
- R2: The result is the first candidate with the smallest error, in the walk order M = 0,1,2,3 (outer), N = N_HI down to N_LO (middle), FD = FD_LO up to FD_HI (inner). By default N_HI = 119, N_LO = 39, FD_LO = 1 and FD_HI = 31.
- R3: The VCO frequency is floor(ref_hz*(N+1)/(M+1)). A candidate whose VCO frequency is below 1000 or above 2,048,000,000 is skipped with all its FD values.
- R4: A candidate output is floor(VCO/(FD+1)). An output of 400,000,000 or more is never reported. A reported `fd_sel` lies in FD_LO..FD_HI.
- R5: `err_hz` equals |out_hz − target_hz|, where target_hz is the value captured at start.
- R6: If no candidate survives the limits, `done` rises with `found` = 0 and every result field 0.
- R7: When a candidate with error 0 is found, the search stops at once. `done` is high one cycle after that candidate is evaluated, and that candidate is reported.
- R8: A `start` pulse while `busy` is high is ignored. The running search keeps its captured operands and reports their result.
- R9: `busy` is high from the cycle after an accepted start until the search ends. `done` rises as `busy` falls, stays high until the next accepted start, and is never high together with `busy`.
- R10: Only a strictly smaller error replaces the stored best, so the reported error never grows during a search and ties go to the earlier candidate in the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| ref_hz | input | FREQ_W | Reference frequency in Hz |
| target_hz | input | FREQ_W | Requested output frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, results stable |
| found | output | 1 | At least one candidate passed the limits |
| m_sel | output | M_W | Chosen input divider field (ratio M+1) |
| n_sel | output | N_W | Chosen feedback field (ratio N+1) |
| fd_sel | output | FD_W | Chosen post divider field (ratio FD+1) |
| out_hz | output | FREQ_W | Output frequency of the chosen settings |
| err_hz | output | FREQ_W | Absolute error of the chosen settings |

## Verification
A fault in the index walker, such as a skipped or repeated N value or a wrong wrap of M, shows up as a final result that differs from the ideal first-minimum candidate. It is visible only once `done` rises, several thousand cycles later. A divider fault corrupts the VCO or output frequency. It then shows as an `out_hz` that does not match floor division of the reported settings, or as a candidate wrongly pruned. A fault in the best-keeper compare shows at once as a growing `err_hz` during the search, or at the end as the wrong tie winner. The tie-winner error needs a stimulus with tied candidates, which the sweep includes.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV1,
    ST_LAUNCH2,
    ST_DIV2,
    ST_ADV
  } srch_state_e;

  // absolute distance between two unsigned values
  function automatic logic [63:0] abs_gap(input logic [63:0] a, input logic [63:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // inclusive window test used for the VCO pruning
  function automatic logic in_window(input logic [63:0] v, input logic [63:0] lo,
                                     input logic [63:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/ps_divider.sv
module ps_divider #(
  parameter int unsigned DW   = 40,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          fin,
  output logic [DW-1:0] quot
);
  localparam int unsigned ROUNDS = DW / STEP;
  localparam int unsigned CNT_W  = $clog2(ROUNDS + 1);

  logic [DW:0]      rem_q, rem_n;
  logic [DW-1:0]    quo_q, quo_n;
  logic [DW-1:0]    dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fin_q;

  // several restoring steps per clock
  always_comb begin
    rem_n = rem_q;
    quo_n = quo_q;
    for (int k = 0; k < STEP; k++) begin
      rem_n = {rem_n[DW-1:0], quo_n[DW-1]};
      quo_n = {quo_n[DW-2:0], 1'b0};
      if (rem_n >= {1'b0, dvs_q}) begin
        rem_n    = rem_n - {1'b0, dvs_q};
        quo_n[0] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else if (go) begin
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
      cnt_q <= CNT_W'(ROUNDS);
      fin_q <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q - CNT_W'(1);
      fin_q <= (cnt_q == CNT_W'(1));
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign fin  = fin_q;
  assign quot = quo_q;
endmodule

// File: rtl/ps_index_walker.sv
module ps_index_walker #(
  parameter int unsigned M_W    = 2,
  parameter int unsigned N_W    = 7,
  parameter int unsigned FD_W   = 5,
  parameter int unsigned M_LAST = 3,
  parameter int unsigned N_HI   = 119,
  parameter int unsigned N_LO   = 39,
  parameter int unsigned FD_LO  = 1,
  parameter int unsigned FD_HI  = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            fd_init,
  input  logic            fd_step,
  input  logic            mn_step,
  output logic [M_W-1:0]  m,
  output logic [N_W-1:0]  n,
  output logic [FD_W-1:0] fd,
  output logic            m_last,
  output logic            n_last,
  output logic            fd_last
);
  logic [M_W-1:0]  m_q;
  logic [N_W-1:0]  n_q;
  logic [FD_W-1:0] fd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q  <= '0;
      n_q  <= '0;
      fd_q <= '0;
    end else begin
      if (load) begin
        m_q <= '0;
        n_q <= N_W'(N_HI);
      end else if (mn_step) begin
        if (n_last) begin
          n_q <= N_W'(N_HI);
          m_q <= m_q + M_W'(1);
        end else begin
          n_q <= n_q - N_W'(1);
        end
      end
      if (fd_init)      fd_q <= FD_W'(FD_LO);
      else if (fd_step) fd_q <= fd_q + FD_W'(1);
    end
  end

  assign m       = m_q;
  assign n       = n_q;
  assign fd      = fd_q;
  assign m_last  = (m_q == M_W'(M_LAST));
  assign n_last  = (n_q == N_W'(N_LO));
  assign fd_last = (fd_q == FD_W'(FD_HI));
endmodule

// File: rtl/ps_best_keeper.sv
module ps_best_keeper #(
  parameter int unsigned M_W    = 2,
  parameter int unsigned N_W    = 7,
  parameter int unsigned FD_W   = 5,
  parameter int unsigned FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              offer,
  input  logic [M_W-1:0]    c_m,
  input  logic [N_W-1:0]    c_n,
  input  logic [FD_W-1:0]   c_fd,
  input  logic [FREQ_W-1:0] c_out,
  input  logic [FREQ_W-1:0] c_err,
  output logic              accept,
  output logic              have,
  output logic [M_W-1:0]    b_m,
  output logic [N_W-1:0]    b_n,
  output logic [FD_W-1:0]   b_fd,
  output logic [FREQ_W-1:0] b_out,
  output logic [FREQ_W-1:0] b_err
);
  // strictly smaller error only: earlier candidates win ties
  assign accept = offer && (!have || (c_err < b_err));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have  <= 1'b0;
      b_m   <= '0;
      b_n   <= '0;
      b_fd  <= '0;
      b_out <= '0;
      b_err <= '0;
    end else if (clear) begin
      have  <= 1'b0;
      b_m   <= '0;
      b_n   <= '0;
      b_fd  <= '0;
      b_out <= '0;
      b_err <= '0;
    end else if (accept) begin
      have  <= 1'b1;
      b_m   <= c_m;
      b_n   <= c_n;
      b_fd  <= c_fd;
      b_out <= c_out;
      b_err <= c_err;
    end
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int unsigned FREQ_W    = 32,
  parameter int unsigned M_W       = 2,
  parameter int unsigned N_W       = 7,
  parameter int unsigned FD_W      = 5,
  parameter int unsigned M_LAST    = 3,
  parameter int unsigned N_HI      = 119,
  parameter int unsigned N_LO      = 39,
  parameter int unsigned FD_LO     = 1,
  parameter int unsigned FD_HI     = 31,
  parameter int unsigned VCO_MIN   = 1000,
  parameter int unsigned VCO_MAX   = 2048000000,
  parameter int unsigned OUT_LIMIT = 400000000,
  parameter int unsigned STEP      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] ref_hz,
  input  logic [FREQ_W-1:0] target_hz,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [M_W-1:0]    m_sel,
  output logic [N_W-1:0]    n_sel,
  output logic [FD_W-1:0]   fd_sel,
  output logic [FREQ_W-1:0] out_hz,
  output logic [FREQ_W-1:0] err_hz
);
  localparam int unsigned PROD_W = FREQ_W + N_W;
  localparam int unsigned DIV_W  = ((PROD_W + STEP - 1) / STEP) * STEP;

  srch_state_e       state_q;
  logic [FREQ_W-1:0] ref_q, tgt_q, fout_q;
  logic              busy_q, done_q;

  logic [M_W-1:0]    w_m;
  logic [N_W-1:0]    w_n;
  logic [FD_W-1:0]   w_fd;
  logic              w_m_last, w_n_last, w_fd_last;

  logic              div_go, div_fin;
  logic [DIV_W-1:0]  div_dvd, div_dvs, div_q;

  // named internal events, also observed by the checker
  logic              launch_w, vco_ok_w, cand_ok_w, offer_w, hit_zero_w;
  logic              accept_w, finish_w, walk_end_w;
  logic [FREQ_W-1:0] cand_err_w;
  logic [N_W:0]      n_plus;

  assign n_plus   = {1'b0, w_n} + (N_W + 1)'(1);
  assign launch_w = (state_q == ST_IDLE) && start;
  assign div_go   = (state_q == ST_MUL) || (state_q == ST_LAUNCH2);
  assign div_dvd  = (state_q == ST_MUL) ? (DIV_W'(ref_q) * DIV_W'(n_plus)) : DIV_W'(fout_q);
  assign div_dvs  = (state_q == ST_MUL) ? (DIV_W'(w_m) + DIV_W'(1)) : (DIV_W'(w_fd) + DIV_W'(1));

  assign vco_ok_w   = in_window(64'(div_q), 64'(VCO_MIN), 64'(VCO_MAX));
  assign cand_ok_w  = 64'(div_q) < 64'(OUT_LIMIT);
  assign cand_err_w = FREQ_W'(abs_gap(64'(div_q), 64'(tgt_q)));
  assign offer_w    = (state_q == ST_DIV2) && div_fin && cand_ok_w;
  assign hit_zero_w = offer_w && (cand_err_w == '0);
  assign walk_end_w = w_m_last && w_n_last;
  assign finish_w   = ((state_q == ST_DIV2) && hit_zero_w) ||
                      ((state_q == ST_ADV) && walk_end_w);

  ps_divider #(.DW(DIV_W), .STEP(STEP)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .fin      (div_fin),
    .quot     (div_q)
  );

  ps_index_walker #(
    .M_W(M_W), .N_W(N_W), .FD_W(FD_W), .M_LAST(M_LAST),
    .N_HI(N_HI), .N_LO(N_LO), .FD_LO(FD_LO), .FD_HI(FD_HI)
  ) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch_w),
    .fd_init ((state_q == ST_DIV1) && div_fin && vco_ok_w),
    .fd_step ((state_q == ST_DIV2) && div_fin && !hit_zero_w && !w_fd_last),
    .mn_step ((state_q == ST_ADV) && !walk_end_w),
    .m       (w_m),
    .n       (w_n),
    .fd      (w_fd),
    .m_last  (w_m_last),
    .n_last  (w_n_last),
    .fd_last (w_fd_last)
  );

  ps_best_keeper #(.M_W(M_W), .N_W(N_W), .FD_W(FD_W), .FREQ_W(FREQ_W)) u_best (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (launch_w),
    .offer  (offer_w),
    .c_m    (w_m),
    .c_n    (w_n),
    .c_fd   (w_fd),
    .c_out  (FREQ_W'(div_q)),
    .c_err  (cand_err_w),
    .accept (accept_w),
    .have   (found),
    .b_m    (m_sel),
    .b_n    (n_sel),
    .b_fd   (fd_sel),
    .b_out  (out_hz),
    .b_err  (err_hz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ref_q   <= '0;
      tgt_q   <= '0;
      fout_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (finish_w) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
      unique case (state_q)
        ST_IDLE: if (start) begin
          ref_q   <= ref_hz;
          tgt_q   <= target_hz;
          busy_q  <= 1'b1;
          done_q  <= 1'b0;
          state_q <= ST_MUL;
        end
        ST_MUL:  state_q <= ST_DIV1;
        ST_DIV1: if (div_fin) begin
          fout_q  <= FREQ_W'(div_q);
          state_q <= vco_ok_w ? ST_LAUNCH2 : ST_ADV;
        end
        ST_LAUNCH2: state_q <= ST_DIV2;
        ST_DIV2: if (div_fin) begin
          if (hit_zero_w)     state_q <= ST_IDLE;
          else if (w_fd_last) state_q <= ST_ADV;
          else                state_q <= ST_LAUNCH2;
        end
        ST_ADV:  state_q <= walk_end_w ? ST_IDLE : ST_MUL;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int unsigned FREQ_W    = 32,
  parameter int unsigned M_W       = 2,
  parameter int unsigned N_W       = 7,
  parameter int unsigned FD_W      = 5,
  parameter int unsigned FD_LO     = 1,
  parameter int unsigned FD_HI     = 31,
  parameter int unsigned OUT_LIMIT = 400000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              found,
  input logic [M_W-1:0]    m_sel,
  input logic [N_W-1:0]    n_sel,
  input logic [FD_W-1:0]   fd_sel,
  input logic [FREQ_W-1:0] out_hz,
  input logic [FREQ_W-1:0] err_hz,
  input logic [FREQ_W-1:0] tgt_q,
  input logic              accept_w,
  input logic              hit_zero_w
);
  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_done_on_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_empty_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (out_hz == '0 && err_hz == '0 && m_sel == '0 &&
                          n_sel == '0 && fd_sel == '0));

  assert_out_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (64'(out_hz) < 64'(OUT_LIMIT)));

  assert_fd_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (32'(fd_sel) >= FD_LO && 32'(fd_sel) <= FD_HI));

  assert_err_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (err_hz == ((out_hz >= tgt_q) ? (out_hz - tgt_q) : (tgt_q - out_hz))));

  assert_err_shrinks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(found)) |-> (found && err_hz <= $past(err_hz)));

  assert_accept_sets_found_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> found);

  assert_zero_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_zero_w |=> (done && !busy && err_hz == '0));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (tgt_q == $past(tgt_q)));
endmodule

bind pll_div_search pll_div_search_chk #(
  .FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W), .FD_W(FD_W),
  .FD_LO(FD_LO), .FD_HI(FD_HI), .OUT_LIMIT(OUT_LIMIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .found      (found),
  .m_sel      (m_sel),
  .n_sel      (n_sel),
  .fd_sel     (fd_sel),
  .out_hz     (out_hz),
  .err_hz     (err_hz),
  .tgt_q      (tgt_q),
  .accept_w   (accept_w),
  .hit_zero_w (hit_zero_w)
);

// File: tb/pll_div_search_bench.sv
module pll_div_search_bench;
  localparam int S_NHI = 47;
  localparam int S_NLO = 39;
  localparam int S_FDH = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // small configuration instance
  logic        s_start = 1'b0;
  logic [31:0] s_ref = '0, s_tgt = '0;
  logic        s_busy, s_done, s_found;
  logic [1:0]  s_m;
  logic [6:0]  s_n;
  logic [4:0]  s_fd;
  logic [31:0] s_out, s_err;

  pll_div_search #(.N_HI(S_NHI), .N_LO(S_NLO), .FD_HI(S_FDH)) u_pll_div_search (
    .clk(clk), .rst_n(rst_n), .start(s_start), .ref_hz(s_ref), .target_hz(s_tgt),
    .busy(s_busy), .done(s_done), .found(s_found), .m_sel(s_m), .n_sel(s_n),
    .fd_sel(s_fd), .out_hz(s_out), .err_hz(s_err)
  );

  // default configuration instance
  logic        f_start = 1'b0;
  logic [31:0] f_ref = '0, f_tgt = '0;
  logic        f_busy, f_done, f_found;
  logic [1:0]  f_m;
  logic [6:0]  f_n;
  logic [4:0]  f_fd;
  logic [31:0] f_out, f_err;

  pll_div_search u_pll_div_search_full (
    .clk(clk), .rst_n(rst_n), .start(f_start), .ref_hz(f_ref), .target_hz(f_tgt),
    .busy(f_busy), .done(f_done), .found(f_found), .m_sel(f_m), .n_sel(f_n),
    .fd_sel(f_fd), .out_hz(f_out), .err_hz(f_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // first-minimum search restated from the requirements
  task automatic model(input longint r, input longint t, input int nhi, input int nlo,
                       input int fdhi, output bit ofound, output int om, output int on,
                       output int ofd, output longint oout, output longint oerr);
    bit stop;
    longint v, o, e;
    stop = 0; ofound = 0; om = 0; on = 0; ofd = 0; oout = 0; oerr = 0;
    for (int m = 0; m < 4; m++) begin
      for (int n = nhi; n >= nlo; n--) begin
        v = r * (n + 1) / (m + 1);
        if (!stop && v >= 1000 && v <= 2048000000) begin
          for (int f = 1; f <= fdhi; f++) begin
            o = v / (f + 1);
            if (!stop && o < 400000000) begin
              e = (o > t) ? o - t : t - o;
              if (!ofound || e < oerr) begin
                ofound = 1; om = m; on = n; ofd = f; oout = o; oerr = e;
              end
              if (e == 0) stop = 1;
            end
          end
        end
      end
    end
  endtask

  task automatic small_start(input longint r, input longint t);
    @(negedge clk);
    s_ref = 32'(r); s_tgt = 32'(t); s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
  endtask

  task automatic small_wait(output int cyc);
    cyc = 0;
    while (!s_done && cyc < 30000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic small_compare(input longint r, input longint t, input string req);
    bit ef; int em, en, efd; longint eo, ee;
    model(r, t, S_NHI, S_NLO, S_FDH, ef, em, en, efd, eo, ee);
    check(s_found == ef && s_m == 2'(em) && s_n == 7'(en) && s_fd == 5'(efd),
          req, "settings {found,m,n,fd}",
          {s_found, 6'(s_m), 8'(s_n), 8'(s_fd)}, {ef, 6'(em), 8'(en), 8'(efd)});
    check(longint'(s_out) == eo && longint'(s_err) == ee, req, "output frequency",
          longint'(s_out), eo);
  endtask

  task automatic small_run(input longint r, input longint t, input string req);
    int cyc;
    small_start(r, t);
    check(s_busy == 1'b1 && s_done == 1'b0, "R9", "busy after start", s_busy, 1);
    small_wait(cyc);
    check(s_done == 1'b1, req, "search finished", s_done, 1);
    small_compare(r, t, req);
    if (s_found) begin
      longint gap;
      gap = (longint'(s_out) > t) ? longint'(s_out) - t : t - longint'(s_out);
      check(longint'(s_err) == gap, "R5", "error is |out-target|", longint'(s_err), gap);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(s_busy == 0 && s_done == 0 && s_found == 0, "R1", "status at reset",
          {s_busy, s_done, s_found}, 0);
    check(s_m == 0 && s_n == 0 && s_fd == 0 && s_out == 0 && s_err == 0 && f_out == 0,
          "R1", "fields at reset", longint'(s_out) + longint'(s_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 sweep over operands
    for (int i = 0; i < 10; i++) begin
      longint r, t;
      r = 3000000 + longint'(i) * 7654321;
      t = 25000000 + longint'(i) * 13579246;
      small_run(r, t, "R2");
    end

    // R3 pruning of a high VCO: M=0 exceeds the ceiling
    small_run(60000000, 300000000, "R3");
    check(s_m != 0, "R3", "M=0 pruned for high VCO", s_m, 1);

    // R4 output ceiling
    small_run(30000000, 500000000, "R4");
    check(s_found && longint'(s_out) < 400000000, "R4", "output below ceiling",
          longint'(s_out), 399999999);

    // R6 nothing survives
    small_run(20, 5000, "R6");
    check(s_found == 0 && s_out == 0 && s_err == 0 && s_m == 0 && s_n == 0 && s_fd == 0,
          "R6", "empty result", longint'(s_found), 0);
    small_run(0, 100, "R6");

    // R10 tie: several settings give 20 MHz, the first in the walk wins
    small_run(4000000, 20000001, "R10");
    check(s_m == 0 && s_n == 39 && s_fd == 7 && s_err == 1, "R10", "tie winner n",
          longint'(s_n), 39);

    // R8 start while busy is ignored
    small_start(5000000, 33000000);
    repeat (20) @(negedge clk);
    s_ref = 32'd9000000; s_tgt = 32'd1000; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    check(s_busy == 1'b1, "R8", "still busy after ignored start", s_busy, 1);
    small_wait(cyc);
    small_compare(5000000, 33000000, "R8");

    // R9 done holds while idle
    repeat (5) @(negedge clk);
    check(s_done == 1'b1 && s_busy == 1'b0, "R9", "done held", {s_done, s_busy}, 2);

    // R7 early stop on the default configuration: first candidate is exact
    @(negedge clk);
    f_ref = 32'd1000000; f_tgt = 32'd60000000; f_start = 1'b1;
    @(negedge clk);
    f_start = 1'b0;
    cyc = 0;
    while (!f_done && cyc < 200000) begin
      @(negedge clk);
      cyc++;
    end
    check(f_done && cyc < 40, "R7", "early stop cycles", cyc, 40);
    check(f_found && f_m == 0 && f_n == 119 && f_fd == 1 && f_out == 60000000 && f_err == 0,
          "R7", "exact settings out", longint'(f_out), 60000000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule